// File: doc/BRIEF.md
# Ping-Pong Hop Table Sequencer

The sequencer keeps two small tables of frequency-hop settings and, at every hop-frame boundary, presents one entry on a registered output bus. Each entry carries a carrier frequency word, a receive IF word, a receive gain-table index and a transmit attenuation. The block does not interpret these fields. A host loads entries through a simple write port and then commits each table. A frame boundary is any change of level, rising or falling, on the asynchronous HOP line.

The next entry is chosen in one of two ways. Auto-increment walks the two tables as one long sequence, or loops over table A alone. Direct mode takes the table and entry from an index input at each boundary. Static mode freezes both tables once hopping runs. Dynamic mode lets the host rewrite the idle table while the other one feeds the output. Dynamic mode also checks a load deadline that is armed by the falling edge of the channel-setup line.

Top module: `hop_seq_top`

## Requirements
- R1: After reset, every output field, `out_tbl_o`, `out_idx_o`, `frame_strobe_o` and all three flags read zero.
- R2: Each rising or falling edge of `hop_i` is one boundary. The entry it selects appears on the outputs at the third rising clock edge after the first edge that samples the new `hop_i` level. `frame_strobe_o` is high for exactly that one cycle. The outputs do not change between boundaries.
- R3: In auto mode with both tables (`two_tables_i`=1), the first boundary after `run_i` rises selects entry 0 of table A (`out_tbl_o`=0). Table A has `last_a_i`+1 entries and table B (`out_tbl_o`=1) has `last_b_i`+1 entries. The sequence runs A0 up to A[last_a], then B0 up to B[last_b], then wraps back to A0.
- R4: In auto mode with `two_tables_i`=0, only table A is used. It loops from A0 to A[last_a] and back to A0, and this works at the full length of 64 entries.
- R5: In direct mode, `dir_sel_i[6]` picks the table (0 for A, 1 for B) and `dir_sel_i[5:0]` picks the entry. If the entry number is beyond that table's length, `err_invalid_o` is set and the previous entry stays on the outputs.
- R6: In static mode (`dyn_mode_i`=0), writes and commits issued while `run_i`=1 are dropped, and `wr_reject_o` is set on the following cycle.
- R7: In dynamic mode, writes to the table that is not on the outputs are stored. Writes to the table on the outputs are dropped and set `wr_reject_o`.
- R8: An accepted write clears the valid state of its table, and a commit sets it again. If a boundary selects an entry in a table that is not valid, `err_invalid_o` is set and the previous entry is held.
- R9: In dynamic two-table mode, a falling edge of `chan_setup_i` arms a deadline. If the idle table is not valid at the next boundary, `err_late_o` is set. If the idle table is valid, the flag stays clear.
- R10: `err_invalid_o`, `err_late_o` and `wr_reject_o` stay set while `run_i` is high, and all three clear once `run_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hop_i | input | 1 | Asynchronous HOP line; each edge is a frame boundary |
| chan_setup_i | input | 1 | Asynchronous channel-setup line; its falling edge arms the load deadline |
| run_i | input | 1 | Hopping active; when low, tables load freely and the flags clear |
| dyn_mode_i | input | 1 | 1 = dynamic table loading, 0 = static |
| direct_mode_i | input | 1 | 1 = direct index, 0 = auto-increment |
| two_tables_i | input | 1 | 1 = use tables A and B, 0 = table A only |
| last_a_i | input | 6 | Last entry number of table A |
| last_b_i | input | 6 | Last entry number of table B |
| dir_sel_i | input | 7 | Direct index: bit 6 is the table, bits 5:0 are the entry |
| wr_en_i | input | 1 | Host write strobe |
| wr_tbl_i | input | 1 | Table to write |
| wr_addr_i | input | 6 | Entry to write |
| wr_freq_i | input | 24 | Carrier frequency word |
| wr_if_i | input | 16 | Receive IF word |
| wr_gain_i | input | 8 | Receive gain-table index |
| wr_attn_i | input | 10 | Transmit attenuation |
| commit_en_i | input | 1 | Mark a table valid |
| commit_tbl_i | input | 1 | Table to commit |
| frame_strobe_o | output | 1 | One-cycle pulse per boundary |
| out_tbl_o | output | 1 | Table of the presented entry |
| out_idx_o | output | 6 | Entry number of the presented entry |
| out_freq_o | output | 24 | Presented carrier frequency |
| out_if_o | output | 16 | Presented receive IF |
| out_gain_o | output | 8 | Presented gain index |
| out_attn_o | output | 10 | Presented attenuation |
| err_invalid_o | output | 1 | Sticky: a boundary hit an invalid or out-of-range entry |
| err_late_o | output | 1 | Sticky: a dynamic load missed its deadline |
| wr_reject_o | output | 1 | Sticky: a write or commit was dropped |

## Verification
A new entry and its strobe are due three clocks after the first clock edge that samples a toggled HOP level. The bench toggles HOP on a falling clock edge. It confirms the strobe is still low two edges later and high after the third, and the monitor compares the entry on the falling edge where the strobe is seen. Error and reject flags register on the boundary cycle or the cycle after a write. They are therefore read only after the hop or write task has waited several idle cycles, and before the next stimulus.

// File: rtl/hop_seq_pkg.sv
package hop_seq_pkg;
  parameter int FREQ_W = 24;
  parameter int IF_W   = 16;
  parameter int GAIN_W = 8;
  parameter int ATTN_W = 10;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [IF_W-1:0]   ifreq;
    logic [GAIN_W-1:0] gain;
    logic [ATTN_W-1:0] attn;
  } hop_entry_t;
endpackage

// File: rtl/hop_edge_sync.sv
module hop_edge_sync #(
  parameter int FALL_ONLY = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic pulse_o
);
  logic [1:0] meta_q;
  logic       last_q;
  logic       det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      last_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      meta_q  <= {meta_q[0], async_i};
      last_q  <= meta_q[1];
      pulse_o <= det;
    end
  end

  generate
    if (FALL_ONLY != 0) begin : g_fall
      assign det = last_q & ~meta_q[1];
      // R9: a fall pulse follows a synchronized high-to-low step
      p_fall_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> ($past(meta_q[1], 2) && !$past(meta_q[1])));
    end else begin : g_any
      assign det = last_q ^ meta_q[1];
      // R2: a boundary pulse follows a synchronized level change
      p_edge_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> ($past(meta_q[1]) != $past(meta_q[1], 2)));
    end
  endgenerate
endmodule

// File: rtl/hop_table_bank.sv
module hop_table_bank
  import hop_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             dyn_i,
  input  logic             active_tbl_i,
  input  logic             wr_en_i,
  input  logic             wr_tbl_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  hop_entry_t       wr_data_i,
  input  logic             commit_en_i,
  input  logic             commit_tbl_i,
  input  logic             rd_tbl_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output hop_entry_t       rd_data_o,
  output logic [1:0]       valid_o,
  output logic             reject_o
);
  localparam int NTBL = 2;

  logic       wr_block, commit_block;
  logic       wr_ok, commit_ok;
  logic       rej_d, rej_q;
  hop_entry_t rd_vec [NTBL];

  // While hopping runs, static mode freezes both tables and dynamic mode
  // protects the table whose entry is on the outputs.
  always_comb begin
    wr_block     = run_i & (~dyn_i | (wr_tbl_i == active_tbl_i));
    commit_block = run_i & (~dyn_i | (commit_tbl_i == active_tbl_i));
    wr_ok        = wr_en_i & ~wr_block;
    commit_ok    = commit_en_i & ~commit_block;
    rej_d        = rej_q | (wr_en_i & wr_block) | (commit_en_i & commit_block);
    if (!run_i) rej_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= 1'b0;
    else        rej_q <= rej_d;
  end

  generate
    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
      hop_entry_t mem_q [DEPTH];
      logic       vld_d, vld_q;
      logic       wr_here;

      assign wr_here = wr_ok & (wr_tbl_i == 1'(t));

      always_ff @(posedge clk) begin
        if (wr_here) mem_q[wr_addr_i] <= wr_data_i;
      end

      always_comb begin
        vld_d = vld_q;
        if (commit_ok && commit_tbl_i == 1'(t)) vld_d = 1'b1;
        else if (wr_here)                       vld_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      assign rd_vec[t]  = mem_q[rd_idx_i];
      assign valid_o[t] = vld_q;
    end
  endgenerate

  assign rd_data_o = rd_vec[rd_tbl_i];
  assign reject_o  = rej_q;

  p_static_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !dyn_i && (wr_en_i || commit_en_i)) |=> reject_o);
  p_active_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && dyn_i && wr_en_i && wr_tbl_i == active_tbl_i) |=> reject_o);
  p_commit_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en_i && !run_i) |=> valid_o[$past(commit_tbl_i)]);
endmodule

// File: rtl/hop_index_ctrl.sv
module hop_index_ctrl
  import hop_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             bnd_i,
  input  logic             setup_fall_i,
  input  logic             dyn_i,
  input  logic             direct_i,
  input  logic             two_i,
  input  logic [IDX_W-1:0] last_a_i,
  input  logic [IDX_W-1:0] last_b_i,
  input  logic [IDX_W:0]   dir_sel_i,
  input  logic [1:0]       valid_i,
  input  hop_entry_t       rd_data_i,
  output logic             rd_tbl_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output hop_entry_t       out_o,
  output logic             out_tbl_o,
  output logic [IDX_W-1:0] out_idx_o,
  output logic             strobe_o,
  output logic             err_inv_o,
  output logic             err_late_o
);
  logic             first_q, first_d;
  logic             ptr_tbl_q, ptr_tbl_d;
  logic [IDX_W-1:0] ptr_idx_q, ptr_idx_d;
  logic             nxt_tbl;
  logic [IDX_W-1:0] nxt_idx;
  logic [IDX_W-1:0] last_cur, last_nxt;
  hop_entry_t       out_q, out_d;
  logic             otbl_q, otbl_d;
  logic [IDX_W-1:0] oidx_q, oidx_d;
  logic             stb_q, stb_d;
  logic             inv_q, inv_d;
  logic             late_q, late_d;
  logic             pend_q, pend_d;
  logic             hop_go, usable, idle_bad;

  assign hop_go   = run_i & bnd_i;
  assign last_cur = ptr_tbl_q ? last_b_i : last_a_i;

  // Choice of the entry for the coming frame
  always_comb begin
    nxt_tbl = ptr_tbl_q;
    nxt_idx = ptr_idx_q;
    if (direct_i) begin
      nxt_tbl = two_i & dir_sel_i[IDX_W];
      nxt_idx = dir_sel_i[IDX_W-1:0];
    end else if (first_q) begin
      nxt_tbl = 1'b0;
      nxt_idx = '0;
    end else if (ptr_idx_q == last_cur) begin
      nxt_tbl = two_i & ~ptr_tbl_q;
      nxt_idx = '0;
    end else begin
      nxt_idx = ptr_idx_q + 1'b1;
    end
  end

  assign last_nxt = nxt_tbl ? last_b_i : last_a_i;
  assign usable   = (nxt_idx <= last_nxt) & valid_i[nxt_tbl];
  assign idle_bad = dyn_i & two_i & ~valid_i[~otbl_q];
  assign rd_tbl_o = nxt_tbl;
  assign rd_idx_o = nxt_idx;

  always_comb begin
    first_d   = first_q;
    ptr_tbl_d = ptr_tbl_q;
    ptr_idx_d = ptr_idx_q;
    out_d     = out_q;
    otbl_d    = otbl_q;
    oidx_d    = oidx_q;
    stb_d     = hop_go;
    inv_d     = inv_q;
    late_d    = late_q;
    pend_d    = pend_q;
    if (!run_i) begin
      first_d = 1'b1;
      inv_d   = 1'b0;
      late_d  = 1'b0;
      pend_d  = 1'b0;
    end else begin
      if (setup_fall_i) pend_d = 1'b1;
      else if (bnd_i)   pend_d = 1'b0;
      if (bnd_i) begin
        first_d   = 1'b0;
        ptr_tbl_d = nxt_tbl;
        ptr_idx_d = nxt_idx;
        if (pend_q && idle_bad) late_d = 1'b1;
        if (usable) begin
          out_d  = rd_data_i;
          otbl_d = nxt_tbl;
          oidx_d = nxt_idx;
        end else begin
          inv_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= 1'b1;
      ptr_tbl_q <= 1'b0;
      ptr_idx_q <= '0;
      out_q     <= '0;
      otbl_q    <= 1'b0;
      oidx_q    <= '0;
      stb_q     <= 1'b0;
      inv_q     <= 1'b0;
      late_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      first_q   <= first_d;
      ptr_tbl_q <= ptr_tbl_d;
      ptr_idx_q <= ptr_idx_d;
      out_q     <= out_d;
      otbl_q    <= otbl_d;
      oidx_q    <= oidx_d;
      stb_q     <= stb_d;
      inv_q     <= inv_d;
      late_q    <= late_d;
      pend_q    <= pend_d;
    end
  end

  assign out_o      = out_q;
  assign out_tbl_o  = otbl_q;
  assign out_idx_o  = oidx_q;
  assign strobe_o   = stb_q;
  assign err_inv_o  = inv_q;
  assign err_late_o = late_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_go |=> ($stable(out_q) && $stable(oidx_q) && $stable(otbl_q)));
  p_strobe_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> $past(bnd_i));
  p_auto_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_go && !direct_i && !first_q && ptr_idx_q != last_cur)
      |=> (ptr_idx_q == IDX_W'($past(ptr_idx_q) + 1'b1)));
  p_late_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && late_q) |=> late_q);
  p_inv_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && inv_q) |=> inv_q);
endmodule

// File: rtl/hop_seq_top.sv
module hop_seq_top
  import hop_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hop_i,
  input  logic              chan_setup_i,
  input  logic              run_i,
  input  logic              dyn_mode_i,
  input  logic              direct_mode_i,
  input  logic              two_tables_i,
  input  logic [IDX_W-1:0]  last_a_i,
  input  logic [IDX_W-1:0]  last_b_i,
  input  logic [IDX_W:0]    dir_sel_i,
  input  logic              wr_en_i,
  input  logic              wr_tbl_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [FREQ_W-1:0] wr_freq_i,
  input  logic [IF_W-1:0]   wr_if_i,
  input  logic [GAIN_W-1:0] wr_gain_i,
  input  logic [ATTN_W-1:0] wr_attn_i,
  input  logic              commit_en_i,
  input  logic              commit_tbl_i,
  output logic              frame_strobe_o,
  output logic              out_tbl_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic [FREQ_W-1:0] out_freq_o,
  output logic [IF_W-1:0]   out_if_o,
  output logic [GAIN_W-1:0] out_gain_o,
  output logic [ATTN_W-1:0] out_attn_o,
  output logic              err_invalid_o,
  output logic              err_late_o,
  output logic              wr_reject_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             bnd, setup_fall;
  logic             rd_tbl, out_tbl;
  logic [IDX_W-1:0] rd_idx;
  logic [1:0]       valid;
  hop_entry_t       wr_data, rd_data, out_entry;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign wr_data = '{freq: wr_freq_i, ifreq: wr_if_i, gain: wr_gain_i, attn: wr_attn_i};

  hop_edge_sync #(.FALL_ONLY(0)) u_hop_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_i(hop_i), .pulse_o(bnd));

  hop_edge_sync #(.FALL_ONLY(1)) u_setup_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_i(chan_setup_i), .pulse_o(setup_fall));

  hop_table_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run_i), .dyn_i(dyn_mode_i),
    .active_tbl_i(out_tbl), .wr_en_i(wr_en_i), .wr_tbl_i(wr_tbl_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data), .commit_en_i(commit_en_i),
    .commit_tbl_i(commit_tbl_i), .rd_tbl_i(rd_tbl), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .valid_o(valid), .reject_o(wr_reject_o));

  hop_index_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run_i), .bnd_i(bnd),
    .setup_fall_i(setup_fall), .dyn_i(dyn_mode_i), .direct_i(direct_mode_i),
    .two_i(two_tables_i), .last_a_i(last_a_i), .last_b_i(last_b_i),
    .dir_sel_i(dir_sel_i), .valid_i(valid), .rd_data_i(rd_data),
    .rd_tbl_o(rd_tbl), .rd_idx_o(rd_idx), .out_o(out_entry),
    .out_tbl_o(out_tbl), .out_idx_o(out_idx_o), .strobe_o(frame_strobe_o),
    .err_inv_o(err_invalid_o), .err_late_o(err_late_o));

  assign out_tbl_o  = out_tbl;
  assign out_freq_o = out_entry.freq;
  assign out_if_o   = out_entry.ifreq;
  assign out_gain_o = out_entry.gain;
  assign out_attn_o = out_entry.attn;

  p_reject_clear_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_i |=> !wr_reject_o);
endmodule

// File: tb/hop_seq_top_tb_top.sv
module hop_seq_top_tb_top;
  import hop_seq_pkg::*;
  localparam int DEPTH = 64;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic hop_in, chan_setup, run, dyn, direct, two;
  logic [IDX_W-1:0] last_a, last_b, wr_addr;
  logic [IDX_W:0]   dir_sel;
  logic wr_en, wr_tbl, commit_en, commit_tbl;
  hop_entry_t wr_e;
  logic frame_strobe, out_tbl, err_inv, err_late, wr_rej;
  logic [IDX_W-1:0]  out_idx;
  logic [FREQ_W-1:0] out_freq;
  logic [IF_W-1:0]   out_if;
  logic [GAIN_W-1:0] out_gain;
  logic [ATTN_W-1:0] out_attn;

  int checks = 0;
  int failures = 0;
  int gen_m [2][DEPTH];
  hop_entry_t exp_q [$];
  int         exp_loc_q [$];
  string      exp_tag_q [$];
  hop_entry_t last_e = '0;
  int         last_loc = 0;

  always #2 clk = ~clk;

  hop_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .hop_i(hop_in), .chan_setup_i(chan_setup),
    .run_i(run), .dyn_mode_i(dyn), .direct_mode_i(direct), .two_tables_i(two),
    .last_a_i(last_a), .last_b_i(last_b), .dir_sel_i(dir_sel),
    .wr_en_i(wr_en), .wr_tbl_i(wr_tbl), .wr_addr_i(wr_addr),
    .wr_freq_i(wr_e.freq), .wr_if_i(wr_e.ifreq), .wr_gain_i(wr_e.gain),
    .wr_attn_i(wr_e.attn), .commit_en_i(commit_en), .commit_tbl_i(commit_tbl),
    .frame_strobe_o(frame_strobe), .out_tbl_o(out_tbl), .out_idx_o(out_idx),
    .out_freq_o(out_freq), .out_if_o(out_if), .out_gain_o(out_gain),
    .out_attn_o(out_attn), .err_invalid_o(err_inv), .err_late_o(err_late),
    .wr_reject_o(wr_rej));

  function automatic hop_entry_t mk(int t, int i, int g);
    hop_entry_t e;
    e.freq  = FREQ_W'(32'h400000 + t * 65536 + i * 256 + g);
    e.ifreq = IF_W'(32'h1000 + i * 3 + g);
    e.gain  = GAIN_W'(t * 128 + i * 2 + (g & 1));
    e.attn  = ATTN_W'(g * 64 + i);
    return e;
  endfunction

  task automatic chk(string tag, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Scoreboard driver side
  task automatic push_entry(int t, int i, string tag);
    last_e   = mk(t, i, gen_m[t][i]);
    last_loc = t * 64 + i;
    exp_q.push_back(last_e);
    exp_loc_q.push_back(last_loc);
    exp_tag_q.push_back(tag);
  endtask

  task automatic push_hold(string tag);
    exp_q.push_back(last_e);
    exp_loc_q.push_back(last_loc);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor: compares each presented frame with the queue head
  always @(negedge clk) begin
    if (rst_n && frame_strobe) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected frame", 1, 0);
      end else begin
        hop_entry_t e;
        int    loc;
        string tg;
        e   = exp_q.pop_front();
        loc = exp_loc_q.pop_front();
        tg  = exp_tag_q.pop_front();
        chk(tg, {out_freq, out_if, out_gain, out_attn}, e);
        chk({tg, " loc"}, out_tbl * 64 + out_idx, loc);
      end
    end
  end

  task automatic do_hop();
    @(negedge clk) hop_in = ~hop_in;
    repeat (6) @(negedge clk);
  endtask

  task automatic hwrite(int t, int i, int g, bit ok);
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = t[0]; wr_addr = IDX_W'(i); wr_e = mk(t, i, g);
    @(negedge clk);
    wr_en = 1'b0;
    if (ok) gen_m[t][i] = g;
  endtask

  task automatic hcommit(int t);
    @(negedge clk);
    commit_en = 1'b1; commit_tbl = t[0];
    @(negedge clk);
    commit_en = 1'b0;
  endtask

  task automatic stop_run();
    @(negedge clk) run = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 invalid flag cleared", err_inv, 0);
    chk("R10 late flag cleared", err_late, 0);
    chk("R10 reject flag cleared", wr_rej, 0);
  endtask

  task automatic setup_pulse();
    @(negedge clk) chan_setup = 1'b1;
    repeat (4) @(negedge clk);
    chan_setup = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hop_in = 1'b0; chan_setup = 1'b0; run = 1'b0;
    dyn = 1'b0; direct = 1'b0; two = 1'b1; last_a = 6'd3; last_b = 6'd2;
    dir_sel = '0; wr_en = 1'b0; wr_tbl = 1'b0; wr_addr = '0; wr_e = '0;
    commit_en = 1'b0; commit_tbl = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 outputs zero", {out_freq, out_if, out_gain, out_attn, out_tbl, out_idx}, 0);
    chk("R1 strobe low", frame_strobe, 0);
    chk("R1 flags zero", {err_inv, err_late, wr_rej}, 0);

    // Initial load of both tables with generation 0
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DEPTH; i++) hwrite(t, i, 0, 1'b1);
    hcommit(0);
    hcommit(1);

    // R3 with a precise R2 timing check on the first boundary
    @(negedge clk) run = 1'b1;
    push_entry(0, 0, "R3 first entry A0");
    @(negedge clk) hop_in = ~hop_in;
    repeat (3) @(negedge clk);
    chk("R2 strobe not yet", frame_strobe, 0);
    chk("R2 output held before due cycle", out_freq, 0);
    @(negedge clk);
    chk("R2 strobe on third edge", frame_strobe, 1);
    @(negedge clk);
    chk("R2 strobe one cycle", frame_strobe, 0);
    repeat (3) @(negedge clk);
    for (int i = 1; i <= 3; i++) begin push_entry(0, i, "R3 table A walk"); do_hop(); end
    for (int i = 0; i <= 2; i++) begin push_entry(1, i, "R3 table B walk"); do_hop(); end
    push_entry(0, 0, "R3 wrap to A0"); do_hop();
    push_entry(0, 1, "R3 after wrap"); do_hop();

    // R6: static mode drops writes while running
    hwrite(0, 1, 7, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6 static write rejected", wr_rej, 1);
    for (int i = 2; i <= 3; i++) begin push_entry(0, i, "R6 contents kept"); do_hop(); end
    for (int i = 0; i <= 2; i++) begin push_entry(1, i, "R6 contents kept"); do_hop(); end
    push_entry(0, 0, "R6 contents kept"); do_hop();
    push_entry(0, 1, "R6 A1 not overwritten"); do_hop();
    chk("R10 reject sticky", wr_rej, 1);
    stop_run();

    // R7 and R8: dynamic loading
    dyn = 1'b1;
    @(negedge clk) run = 1'b1;
    push_entry(0, 0, "R7 start A0"); do_hop();
    hwrite(1, 0, 2, 1'b1);
    hcommit(1);
    repeat (2) @(negedge clk);
    chk("R7 idle write accepted", wr_rej, 0);
    hwrite(0, 2, 9, 1'b0);
    repeat (2) @(negedge clk);
    chk("R7 active write rejected", wr_rej, 1);
    push_entry(0, 1, "R7 walk"); do_hop();
    push_entry(0, 2, "R7 active entry untouched"); do_hop();
    push_entry(0, 3, "R7 walk"); do_hop();
    push_entry(1, 0, "R7 reloaded idle entry"); do_hop();
    hwrite(0, 0, 3, 1'b1);
    push_entry(1, 1, "R8 walk"); do_hop();
    push_entry(1, 2, "R8 walk"); do_hop();
    chk("R8 no error yet", err_inv, 0);
    push_hold("R8 invalid table holds entry"); do_hop();
    chk("R8 invalid flag", err_inv, 1);
    push_hold("R8 still invalid"); do_hop();
    hcommit(0);
    push_entry(0, 2, "R8 table valid again"); do_hop();
    push_entry(0, 3, "R8 walk"); do_hop();
    for (int i = 0; i <= 2; i++) begin push_entry(1, i, "R8 walk"); do_hop(); end
    push_entry(0, 0, "R8 new A0 content"); do_hop();

    // R9: load deadline met, then missed
    setup_pulse();
    hwrite(1, 2, 4, 1'b1);
    hcommit(1);
    push_entry(0, 1, "R9 deadline met"); do_hop();
    chk("R9 no late flag", err_late, 0);
    setup_pulse();
    hwrite(1, 1, 5, 1'b1);
    push_entry(0, 2, "R9 deadline missed"); do_hop();
    chk("R9 late flag", err_late, 1);
    hcommit(1);
    push_entry(0, 3, "R9 walk"); do_hop();
    for (int i = 0; i <= 2; i++) begin push_entry(1, i, "R9 late-loaded table"); do_hop(); end
    chk("R10 late sticky", err_late, 1);
    stop_run();

    // R5: direct index
    direct = 1'b1;
    @(negedge clk) run = 1'b1;
    dir_sel = {1'b1, 6'd2}; push_entry(1, 2, "R5 direct B2"); do_hop();
    dir_sel = {1'b0, 6'd3}; push_entry(0, 3, "R5 direct A3"); do_hop();
    dir_sel = {1'b1, 6'd5}; push_hold("R5 out of range holds"); do_hop();
    chk("R5 out of range flag", err_inv, 1);
    dir_sel = {1'b0, 6'd0}; push_entry(0, 0, "R5 direct A0"); do_hop();
    stop_run();

    // R4: single table at full length
    direct = 1'b0; two = 1'b0; dyn = 1'b0; last_a = 6'd63;
    @(negedge clk) run = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin push_entry(0, i, "R4 single loop"); do_hop(); end
    push_entry(0, 0, "R4 wrap at 64"); do_hop();
    push_entry(0, 1, "R4 after wrap"); do_hop();

    repeat (4) @(negedge clk);
    chk("R2 all frames seen", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule